// File: doc/BRIEF.md
# Mode-Selectable Mantissa Rounding Unit

This block rounds an unpacked floating-point mantissa to its target precision. The mantissa arrives already aligned. Its two lowest bits are the guard bit (upper) and the round bit (lower). Every bit that was shifted out further down is collapsed into a separate sticky input. A 2-bit mode input selects one of four rounding directions.

The unit drops the guard and round bits and decides whether to add one at the new least-significant bit. It returns the rounded mantissa with one extra carry bit, an increment flag and an inexact flag. From the same mode and sign it also reports whether a result that overflows should saturate to infinity or to the largest finite magnitude.

Normalising after a carry-out, handling the exponent and packing the result belong to the surrounding datapath. All outputs are registered and appear one clock after their inputs.

Top module: `fpr_round_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output register is cleared to zero on that edge.
- R2: One cycle after any input set, `rnd_mant_o` equals `mant_i` shifted right by two, plus `rnd_inc_o`. It is held in `MANT_W-1` bits, and its top bit is the carry position.
- R3: When `mant_i[1]` (guard), `mant_i[0]` (round) and `sticky_i` are all zero, the result is exact: `rnd_inc_o` and `rnd_inexact_o` are both 0.
- R4: `rnd_inexact_o` is 1 exactly when guard, round or sticky is 1, in every mode.
- R5: Mode 0 (nearest, ties to even) increments only when guard is 1 and at least one of these is 1: round, sticky, or bit 2 of `mant_i` (the LSB after the shift).
- R6: Mode 1 (toward zero) never increments.
- R7: Mode 2 (toward plus infinity) increments exactly when the result is inexact and `sign_i` is 0. Mode 3 (toward minus infinity) increments exactly when the result is inexact and `sign_i` is 1.
- R8: The increment carries through the whole kept mantissa. When the shifted mantissa is all ones and an increment occurs, `rnd_mant_o` shows only its top (carry) bit set.
- R9: `ovf_inf_o` depends only on the mode and the sign. It is 1 in mode 0, 0 in mode 1, equal to `!sign_i` in mode 2 and equal to `sign_i` in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mant_i | input | MANT_W | Aligned mantissa; bit 1 guard, bit 0 round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| mode_i | input | 2 | Rounding mode: 0 nearest, 1 zero, 2 plus, 3 minus |
| rnd_mant_o | output | MANT_W-1 | Rounded mantissa, top bit is carry |
| rnd_inc_o | output | 1 | Mantissa was incremented |
| rnd_inexact_o | output | 1 | Guard, round or sticky was nonzero |
| ovf_inf_o | output | 1 | Overflow of this sign goes to infinity |

## Verification
The embedded properties check these relations every cycle:
- the rounded mantissa always equals the shifted input plus the increment flag;
- an exact input never increments or raises inexact;
- an increment never occurs without inexact;
- toward-zero never increments;
- the overflow choice in the nearest and toward-zero modes.

Other behaviours need the bench's exhaustive sweep of a small mantissa over every mode, sign and sticky value. These are the tie-breaking to even, the sign dependence of the directed modes, the carry out of an all-ones mantissa and the cleared state under reset.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;
endpackage

// File: rtl/fpr_incr_decide.sv
module fpr_incr_decide
  import fpr_pkg::*;
(
  input  logic   sign,
  input  logic   guard,
  input  logic   rbit,
  input  logic   sticky,
  input  logic   lsb,
  input  rmode_e mode,
  output logic   inc,
  output logic   inexact
);
  logic lost;
  assign lost    = guard | rbit | sticky;
  assign inexact = lost;

  always_comb begin
    inc = 1'b0;
    if (lost) begin
      case (mode)
        RM_ZERO: inc = 1'b0;
        RM_UP:   inc = ~sign;
        RM_DOWN: inc = sign;
        default: inc = guard & (rbit | sticky | lsb);
      endcase
    end
  end

  // R6: toward zero never produces an increment
  always_comb begin
    if (mode == RM_ZERO) a_rz_no_inc_r6: assert (inc == 1'b0);
  end
endmodule

// File: rtl/fpr_mant_incr.sv
module fpr_mant_incr #(
  parameter int KEEP_W = 8
) (
  input  logic [KEEP_W-1:0] base,
  input  logic              inc,
  output logic [KEEP_W:0]   sum
);
  logic [KEEP_W:0] carry;
  assign carry[0] = inc;

  for (genvar i = 0; i < KEEP_W; i++) begin : g_chain
    assign sum[i]     = base[i] ^ carry[i];
    assign carry[i+1] = base[i] & carry[i];
  end
  assign sum[KEEP_W] = carry[KEEP_W];
endmodule

// File: rtl/fpr_ovf_select.sv
module fpr_ovf_select
  import fpr_pkg::*;
(
  input  logic   sign,
  input  rmode_e mode,
  output logic   to_inf
);
  always_comb begin
    case (mode)
      RM_ZERO: to_inf = 1'b0;
      RM_UP:   to_inf = ~sign;
      RM_DOWN: to_inf = sign;
      default: to_inf = 1'b1;
    endcase
  end
endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit
  import fpr_pkg::*;
#(
  parameter int MANT_W = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sign_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [1:0]        mode_i,
  output logic [MANT_W-2:0] rnd_mant_o,
  output logic              rnd_inc_o,
  output logic              rnd_inexact_o,
  output logic              ovf_inf_o
);
  localparam int KEEP_W = MANT_W - 2;
  localparam int RES_W  = KEEP_W + 1;

  rmode_e            mode;
  logic [KEEP_W-1:0] base;
  logic              inc_c, inexact_c, to_inf_c;
  logic [RES_W-1:0]  sum_c;

  assign mode = rmode_e'(mode_i);
  assign base = mant_i[MANT_W-1:2];

  fpr_incr_decide u_decide (
    .sign    (sign_i),
    .guard   (mant_i[1]),
    .rbit    (mant_i[0]),
    .sticky  (sticky_i),
    .lsb     (mant_i[2]),
    .mode    (mode),
    .inc     (inc_c),
    .inexact (inexact_c)
  );

  fpr_mant_incr #(.KEEP_W(KEEP_W)) u_incr (
    .base (base),
    .inc  (inc_c),
    .sum  (sum_c)
  );

  fpr_ovf_select u_ovf (
    .sign   (sign_i),
    .mode   (mode),
    .to_inf (to_inf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_mant_o    <= '0;
      rnd_inc_o     <= 1'b0;
      rnd_inexact_o <= 1'b0;
      ovf_inf_o     <= 1'b0;
    end else begin
      rnd_mant_o    <= sum_c;
      rnd_inc_o     <= inc_c;
      rnd_inexact_o <= inexact_c;
      ovf_inf_o     <= to_inf_c;
    end
  end

  p_mant_sum_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rnd_mant_o == ({1'b0, $past(base)} + {{KEEP_W{1'b0}}, rnd_inc_o}));

  p_exact_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (mant_i[1:0] == 2'b00 && !sticky_i) |=> (!rnd_inc_o && !rnd_inexact_o));

  p_inc_needs_inexact_r4: assert property (@(posedge clk) disable iff (rst)
    rnd_inc_o |-> rnd_inexact_o);

  p_rz_no_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1) |=> !rnd_inc_o);

  p_rn_inf_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0) |=> ovf_inf_o);

  p_rz_finite_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd1) |=> !ovf_inf_o);
endmodule

// File: tb/fpr_round_unit_tb.sv
`timescale 1ns/1ps
module fpr_round_unit_tb;
  localparam int MANT_W = 10;
  localparam int KEEP_W = MANT_W - 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sign_i = 1'b0;
  logic [MANT_W-1:0] mant_i = '0;
  logic              sticky_i = 1'b0;
  logic [1:0]        mode_i = 2'd0;
  logic [MANT_W-2:0] rnd_mant_o;
  logic              rnd_inc_o, rnd_inexact_o, ovf_inf_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fpr_round_unit #(.MANT_W(MANT_W)) u_dut (
    .clk, .rst, .sign_i, .mant_i, .sticky_i, .mode_i,
    .rnd_mant_o, .rnd_inc_o, .rnd_inexact_o, .ovf_inf_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d sign %0d mant %0d sticky %0d)",
               req, act, exp, mode_i, sign_i, mant_i, sticky_i);
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: outputs cleared under reset despite active inputs
    mant_i = '1; sticky_i = 1'b1; mode_i = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 mant", int'(rnd_mant_o), 0);
    chk("R1 inc", int'(rnd_inc_o), 0);
    chk("R1 inexact", int'(rnd_inexact_o), 0);
    chk("R1 ovf", int'(ovf_inf_o), 0);
    rst = 1'b0;

    for (int md = 0; md < 4; md++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int st = 0; st < 2; st++) begin
          for (int m = 0; m < (1 << MANT_W); m++) begin
            int g, r, base, lsb, lost, e_inc, e_inf;
            @(negedge clk);
            mode_i = md[1:0]; sign_i = sg[0]; sticky_i = st[0]; mant_i = m[MANT_W-1:0];
            g = (m >> 1) & 1; r = m & 1; base = m >> 2; lsb = base & 1;
            lost = (g | r | st) != 0 ? 1 : 0;
            case (md)
              0: e_inc = (g == 1 && (r == 1 || st == 1 || lsb == 1)) ? 1 : 0;
              1: e_inc = 0;
              2: e_inc = (lost == 1 && sg == 0) ? 1 : 0;
              default: e_inc = (lost == 1 && sg == 1) ? 1 : 0;
            endcase
            case (md)
              0: e_inf = 1;
              1: e_inf = 0;
              2: e_inf = 1 - sg;
              default: e_inf = sg;
            endcase
            @(negedge clk);
            chk("R2 mant", int'(rnd_mant_o), base + e_inc);
            chk("R4 inexact", int'(rnd_inexact_o), lost);
            if (lost == 0) chk("R3 exact inc", int'(rnd_inc_o), 0);
            else if (md == 0) chk("R5 nearest inc", int'(rnd_inc_o), e_inc);
            else if (md == 1) chk("R6 zero inc", int'(rnd_inc_o), 0);
            else chk("R7 directed inc", int'(rnd_inc_o), e_inc);
            if (base == (1 << KEEP_W) - 1 && e_inc == 1)
              chk("R8 carry out", int'(rnd_mant_o), 1 << KEEP_W);
            chk("R9 overflow", int'(ovf_inf_o), e_inf);
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule